// File: doc/BRIEF.md
# Power-of-Two Interval Timer with Latching One-Shot

This block divides its clock by a power of two chosen from four fixed stage counts. A binary counter counts up to half of the chosen period and then flips the output. In recurrent mode the output flips at every such point, so it forms a square wave with a 50% duty cycle and a period of 2^n clocks. In one-shot mode the output flips once and then holds its new level until something clears the timer.

Several events clear the timer: the synchronous system reset, a master-clear input, and a power-on pulse input. The power-on pulse only counts while the auto-clear enable is active, which means its disable pin is held low. A low-to-high change on the mode input also clears the timer. After any clear the counter is zero and the output is at the level chosen by the phase input. The stage select can change while the timer is counting. The counter keeps its value, and the new terminal count applies from the next clock.

Top module: `pow2_timer`

## Requirements
- R1: `sel` chooses n, the number of stages. In the encoding below, `sel[0]` is the low-order select line. 2'b00 gives 13 stages, 2'b10 gives 10 stages, 2'b01 gives 8 stages and 2'b11 gives 16 stages.
- R2: With `recur` high and no clear, `tmr_out` first flips 2^(n-1) clock edges after the last edge that sampled a clear. After that it flips every 2^(n-1) edges, so the period is 2^n clocks.
- R3: While `mreset` is high, the counter stays at zero and `tmr_out` equals `phase` from the edge after. It never toggles during this time.
- R4: After any clear, `tmr_out` starts at the level of `phase`: low when `phase` is 0 and high when `phase` is 1.
- R5: With `autorst_dis` low, a high `por_pulse` clears the timer exactly as `mreset` does. With `autorst_dis` high, `por_pulse` has no effect on the output timing.
- R6: With `recur` low, `tmr_out` flips once, 2^(n-1) edges after the clear. It then holds that level until the next clear.
- R7: A rise of `recur` from 0 to 1 clears the counter, restores `tmr_out` to `phase` and releases the one-shot latch. The next flip follows 2^(n-1) edges later.
- R8: A change of `sel` does not clear the counter. If the count is already at or past the new terminal value 2^(n-1)-1, the output flips on the next edge. Otherwise it flips when the count reaches that value.
- R9: The synchronous `rst` clears the timer in the same way as `mreset`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock being divided |
| rst | input | 1 | Synchronous active-high system reset |
| mreset | input | 1 | Master clear, active high |
| por_pulse | input | 1 | Power-on clear pulse, active high |
| autorst_dis | input | 1 | When high, `por_pulse` is ignored |
| phase | input | 1 | Output level after a clear |
| recur | input | 1 | 1 selects recurrent mode, 0 selects one-shot mode |
| sel | input | 2 | Stage-count select |
| tmr_out | output | 1 | Timer output |

## Verification
Every clear source acts at the edge that samples it, so the counter and the output level are due one edge later. A flip is due exactly 2^(n-1) edges after the last clear edge, or exactly one edge after a `sel` change that puts the count at or past the new terminal value. The bench changes its inputs one nanosecond after an edge and samples the output at the same point, after every edge. It counts edges from the clear edge and compares the count with the number the requirement gives. A per-edge reference model also checks every sampled cycle during the random phase.

// File: rtl/pow2_timer_pkg.sv
`timescale 1ns/1ps
package pow2_timer_pkg;

    localparam int unsigned MAX_STAGES = 16;

    // bit 0 is the low-order select line
    typedef enum logic [1:0] {
        SEL_S13 = 2'b00,
        SEL_S8  = 2'b01,
        SEL_S10 = 2'b10,
        SEL_S16 = 2'b11
    } stage_sel_e;

    typedef struct packed {
        logic tick;   // terminal count reached this cycle
        logic hold;   // counter frozen by the one-shot latch
    } cnt_stat_t;

    function automatic int unsigned stages_of(stage_sel_e s);
        case (s)
            SEL_S13: return 13;
            SEL_S8:  return 8;
            SEL_S10: return 10;
            default: return 16;
        endcase
    endfunction

endpackage

// File: rtl/ptmr_ctl.sv
`timescale 1ns/1ps
module ptmr_ctl (
    input  logic clk,
    input  logic rst,
    input  logic mreset,
    input  logic por_pulse,
    input  logic autorst_dis,
    input  logic recur,
    output logic clear
);
    logic recur_q;
    logic recur_rise;

    always_ff @(posedge clk) begin
        if (rst) recur_q <= 1'b1;
        else     recur_q <= recur;
    end

    assign recur_rise = recur & ~recur_q;
    assign clear = rst | mreset | (por_pulse & ~autorst_dis) | recur_rise;
endmodule

// File: rtl/ptmr_count.sv
`timescale 1ns/1ps
module ptmr_count
    import pow2_timer_pkg::*;
#(
    parameter int unsigned CW = MAX_STAGES - 1
) (
    input  logic          clk,
    input  logic          clear,
    input  logic          hold,
    input  logic [1:0]    sel,
    output logic [CW-1:0] cnt,
    output cnt_stat_t     stat
);
    int unsigned   nst;
    logic [CW-1:0] term;

    always_comb begin
        nst       = stages_of(stage_sel_e'(sel));
        term      = CW'((32'd1 << (nst - 1)) - 32'd1);
        stat.hold = hold;
        stat.tick = ~hold && (cnt >= term);
    end

    always_ff @(posedge clk) begin
        if (clear)          cnt <= '0;
        else if (hold)      cnt <= cnt;
        else if (stat.tick) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ptmr_out.sv
`timescale 1ns/1ps
module ptmr_out
    import pow2_timer_pkg::*;
(
    input  logic      clk,
    input  logic      clear,
    input  logic      phase,
    input  logic      recur,
    input  cnt_stat_t stat,
    output logic      out_q,
    output logic      latched
);
    always_ff @(posedge clk) begin
        if (clear) begin
            out_q   <= phase;
            latched <= 1'b0;
        end else if (stat.tick) begin
            out_q   <= ~out_q;
            latched <= ~recur;
        end
    end
endmodule

// File: rtl/pow2_timer.sv
`timescale 1ns/1ps
module pow2_timer
    import pow2_timer_pkg::*;
#(
    parameter int unsigned STAGES_MAX = MAX_STAGES
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mreset,
    input  logic       por_pulse,
    input  logic       autorst_dis,
    input  logic       phase,
    input  logic       recur,
    input  logic [1:0] sel,
    output logic       tmr_out
);
    localparam int unsigned CW = STAGES_MAX - 1;

    logic          clear;
    logic          latched;
    logic [CW-1:0] cnt;
    cnt_stat_t     stat;
    logic          tick;

    ptmr_ctl u_ctl (
        .clk(clk), .rst(rst), .mreset(mreset), .por_pulse(por_pulse),
        .autorst_dis(autorst_dis), .recur(recur), .clear(clear)
    );

    ptmr_count #(.CW(CW)) u_cnt (
        .clk(clk), .clear(clear), .hold(latched & ~recur), .sel(sel),
        .cnt(cnt), .stat(stat)
    );

    ptmr_out u_out (
        .clk(clk), .clear(clear), .phase(phase), .recur(recur),
        .stat(stat), .out_q(tmr_out), .latched(latched)
    );

    assign tick = stat.tick;
endmodule

// File: rtl/pow2_timer_chk.sv
`timescale 1ns/1ps
module pow2_timer_chk #(
    parameter int unsigned CW = 15
) (
    input logic          clk,
    input logic          rst,
    input logic          mreset,
    input logic          por_pulse,
    input logic          autorst_dis,
    input logic          phase,
    input logic          recur,
    input logic          tmr_out,
    input logic          tick,
    input logic          latched,
    input logic [CW-1:0] cnt
);
    // R3
    mreset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        mreset |=> (cnt == '0) && (tmr_out == $past(phase)));

    // R5
    por_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (por_pulse && !autorst_dis) |=> (cnt == '0) && (tmr_out == $past(phase)));

    // R7
    mode_rise_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(recur) |=> (cnt == '0) && (tmr_out == $past(phase)) && !latched);

    // R6
    oneshot_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (latched && !recur && !mreset && !(por_pulse && !autorst_dis))
        |=> $stable(tmr_out));

    // R2
    flip_only_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !mreset && !(por_pulse && !autorst_dis) && !$rose(recur))
        |=> $stable(tmr_out));
endmodule

bind pow2_timer pow2_timer_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst(rst), .mreset(mreset), .por_pulse(por_pulse),
    .autorst_dis(autorst_dis), .phase(phase), .recur(recur),
    .tmr_out(tmr_out), .tick(tick), .latched(latched), .cnt(cnt)
);

// File: tb/pow2_timer_tb_top.sv
`timescale 1ns/1ps
module pow2_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mreset = 1'b0;
    logic       por_pulse = 1'b0;
    logic       autorst_dis = 1'b1;
    logic       phase = 1'b0;
    logic       recur = 1'b1;
    logic [1:0] sel = 2'b01;
    logic       tmr_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pow2_timer dut_i (
        .clk(clk), .rst(rst), .mreset(mreset), .por_pulse(por_pulse),
        .autorst_dis(autorst_dis), .phase(phase), .recur(recur),
        .sel(sel), .tmr_out(tmr_out)
    );

    // reference model, built from the requirements
    int   m_cnt = 0;
    logic m_out = 1'b0;
    logic m_lat = 1'b0;
    logic m_rq  = 1'b1;
    bit   model_on = 0;

    function automatic int half_of(logic [1:0] s);
        case (s)
            2'b00:   return 4096;   // 13 stages
            2'b10:   return 512;    // 10 stages
            2'b01:   return 128;    // 8 stages
            default: return 32768;  // 16 stages
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst || mreset || (por_pulse && !autorst_dis) || (recur && !m_rq)) begin
            m_cnt <= 0; m_out <= phase; m_lat <= 1'b0;
        end else if (!(m_lat && !recur)) begin
            if (m_cnt >= half_of(sel) - 1) begin
                m_cnt <= 0; m_out <= ~m_out; m_lat <= ~recur;
            end else begin
                m_cnt <= m_cnt + 1;
            end
        end
        m_rq <= rst ? 1'b1 : recur;
    end

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        if (model_on) check("R2 model", int'(tmr_out), int'(m_out));
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic do_clear();
        mreset = 1'b1; step(); mreset = 1'b0;
    endtask

    function automatic int wait_dummy(int x); return x; endfunction

    task automatic edges_to_flip(output int n);
        logic prev;
        prev = tmr_out;
        n = 0;
        while (tmr_out == prev && n < 40000) begin
            step(); n++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual expired expected finished");
        finish_run();
    end

    initial begin
        int n;
        // R9 reset state
        steps(2);
        check("R9 reset level", int'(tmr_out), 0);
        phase = 1'b1; step(); rst = 1'b0;
        check("R4 reset level phase high", int'(tmr_out), 1);

        // R1/R2 period per select code, recurrent
        phase = 1'b0; recur = 1'b1;
        for (int k = 0; k < 4; k++) begin
            sel = 2'(k);
            do_clear();
            edges_to_flip(n);
            check("R1 first flip", n, half_of(sel));
            check("R2 level after flip", int'(tmr_out), 1);
            edges_to_flip(n);
            check("R2 second half", n, half_of(sel));
        end

        // R4 phase high start
        sel = 2'b01; phase = 1'b1; do_clear();
        check("R4 start high", int'(tmr_out), 1);
        edges_to_flip(n);
        check("R4 flip from high", n, 128);

        // R3 master reset held
        mreset = 1'b1;
        steps(300);
        check("R3 held level", int'(tmr_out), 1);
        phase = 1'b0; step();
        check("R3 follows phase", int'(tmr_out), 0);
        mreset = 1'b0;
        edges_to_flip(n);
        check("R3 release", n, 128);

        // R6 one-shot latch
        recur = 1'b0; phase = 1'b1; do_clear();
        edges_to_flip(n);
        check("R6 one-shot flip", n, 128);
        check("R6 flipped level", int'(tmr_out), 0);
        steps(600);
        check("R6 latched level", int'(tmr_out), 0);

        // R7 mode rise releases
        recur = 1'b1; step();
        check("R7 restore level", int'(tmr_out), 1);
        edges_to_flip(n);
        check("R7 next flip", n, 128);

        // R5 power-on pulse gating
        phase = 1'b0; do_clear();
        steps(50);
        autorst_dis = 1'b1; por_pulse = 1'b1; step(); por_pulse = 1'b0;
        edges_to_flip(n);
        check("R5 pulse ignored", n, 77);
        do_clear();
        steps(50);
        autorst_dis = 1'b0; por_pulse = 1'b1; step(); por_pulse = 1'b0;
        check("R5 pulse level", int'(tmr_out), 0);
        edges_to_flip(n);
        check("R5 pulse clears", n, 128);

        // R8 select change during counting
        sel = 2'b11; do_clear();
        steps(300);
        sel = 2'b01;
        edges_to_flip(n);
        check("R8 shrink flips next edge", n, 1);
        edges_to_flip(n);
        check("R8 new period", n, 128);
        do_clear();
        steps(100);
        sel = 2'b10;
        edges_to_flip(n);
        check("R8 grow", n, 412);

        // random phase against model
        void'($urandom(32'd1234));
        rst = 1'b1; step(); rst = 1'b0;
        model_on = 1;
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 199) == 0) mreset = 1'b1; else mreset = 1'b0;
            por_pulse = ($urandom_range(0, 149) == 0);
            if ($urandom_range(0, 299) == 0) autorst_dis = ~autorst_dis;
            if ($urandom_range(0, 99) == 0) phase = ~phase;
            if ($urandom_range(0, 399) == 0) recur = ~recur;
            if ($urandom_range(0, 499) == 0) sel = ($urandom_range(0, 1) == 0) ? 2'b01 : 2'b10;
            step();
        end
        n = wait_dummy(0);
        finish_run();
    end
endmodule